// File: doc/BRIEF.md
# Effective address and cycle unit

This unit works out where an 8-bit processor instruction's operand lives and how many clock cycles the instruction takes. The caller supplies the addressing mode, the one or two operand bytes, the two index registers, the address that follows the instruction, the kind of access (read, store or read-modify-write) and, for relative branches, whether the branch is taken. The unit answers with the effective address, the unindexed base address and the total cycle count. The count includes the extra cycle for crossing a page on indexed reads and the extra cycles for taken branches.

Three modes need a 16-bit pointer from memory: indexed indirect, indirect indexed, and the indirect jump. For these the unit fetches the two pointer bytes one at a time over a simple request/acknowledge byte port. The second byte always comes from the same 256-byte page as the first. The low address byte wraps to zero and the high byte does not change, which gives both the zero-page pointer wrap and the indirect-jump page quirk. Opcode decoding and the operand access itself are left to the caller.

A request is taken only while `busy_o` is low. The result appears with a one-cycle `done_o` pulse and stays on the outputs until the next result.

Top module: `eacyc_unit`

## Requirements
- R1: A `start_i` pulse is accepted only while `busy_o` is low. A start that arrives while busy is ignored: it does not change the in-flight result and does not produce a second `done_o`.
- R2: Zero-page indexed (mode 2 adds X, mode 3 adds Y) gives ea = {8'h00, (op_lo + index) mod 256} and base = {8'h00, op_lo}. Zero page (mode 1) gives ea = base = {8'h00, op_lo}.
- R3: Absolute (mode 4) gives ea = base = {op_hi, op_lo}. Absolute indexed (mode 5 adds X, mode 6 adds Y) gives base = {op_hi, op_lo} and ea = base + index, modulo 65536.
- R4: Indexed indirect (mode 7) reads the pointer low byte at zero-page address (op_lo + X) mod 256 and the high byte at the next zero-page address, modulo 256. ea = base = pointer.
- R5: Indirect indexed (mode 8) reads the pointer at op_lo and (op_lo + 1) mod 256 in zero page. base = pointer and ea = pointer + Y, modulo 65536.
- R6: Indirect jump (mode 9) reads the target low byte at {op_hi, op_lo} and the high byte at {op_hi, (op_lo + 1) mod 256}. ea = target, base = {op_hi, op_lo}, and cycles = 5.
- R7: Base cycle counts for read / store / read-modify-write are:
  - zero page: 3 / 3 / 5
  - zero-page indexed and absolute: 4 / 4 / 6
  - absolute indexed: 4 / 5 / 7
  - indexed indirect: 6 / 6 / 8
  - indirect indexed: 5 / 6 / 8

  Kind encoding: 0 = read, 1 = store, 2 or 3 = read-modify-write.
- R8: Modes 5, 6 and 8 add one cycle when ea[15:8] differs from base[15:8], but only for kind 0 (read). Stores and read-modify-writes never add it.
- R9: Branch (mode 10): base = next_pc and ea = next_pc + sign-extended op_lo. Cycles are 2 when not taken, 3 when taken with ea[15:8] == next_pc[15:8], and 4 when taken across a page.
- R10: Immediate (mode 0), and the reserved modes 11 to 15, give ea = base = next_pc - 1 with 2 cycles. Modes 0 to 6 and 10 to 15 make no memory request.
- R11: `done_o` is high for exactly one cycle. It is seen two samples after the cycle in which the request was driven (non-pointer modes) or after the cycle of the last pointer acknowledge. ea, base and cycles hold their values until the next `done_o`.
- R12: While `mem_req_o` is high and `mem_ack_i` is low, the request stays asserted and `mem_addr_o` holds its value.
- R13: After reset `done_o`, `busy_o` and `mem_req_o` are low, and ea, base and cycles are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code (see requirements) |
| kind_i | input | 2 | Access kind: 0 read, 1 store, 2/3 read-modify-write |
| op_lo_i | input | 8 | First operand byte (branch offset for mode 10) |
| op_hi_i | input | 8 | Second operand byte |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| next_pc_i | input | 16 | Address of the byte after the instruction |
| taken_i | input | 1 | Branch condition met |
| busy_o | output | 1 | Request in progress; new starts ignored |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 16 | Pointer byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 16 | Effective address |
| base_o | output | 16 | Base (unindexed) address |
| cycles_o | output | 4 | Total instruction cycles |

## Verification
The hardest cases to reach are pointer fetches that straddle the end of a page. One is a zero-page pointer at $FF, whose high byte must come from $00. The other is an indirect-jump pointer at $xxFF, whose high byte must come from $xx00. Each must also be combined with a variable acknowledge latency, so that the held request and the one-cycle done pulse are tested under stalls. The stimulus programs the bench's zero-page bytes at $FF, $00, $40 and $41 and picks index values that push the indexed result across a page. It also sends a second start, with different operands, into the middle of a stalled fetch to show that it is dropped.

// File: rtl/eacyc_pkg.sv
package eacyc_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int MW = 4;

  localparam logic [MW-1:0] M_IMM    = 4'd0;
  localparam logic [MW-1:0] M_ZP     = 4'd1;
  localparam logic [MW-1:0] M_ZPX    = 4'd2;
  localparam logic [MW-1:0] M_ZPY    = 4'd3;
  localparam logic [MW-1:0] M_ABS    = 4'd4;
  localparam logic [MW-1:0] M_ABSX   = 4'd5;
  localparam logic [MW-1:0] M_ABSY   = 4'd6;
  localparam logic [MW-1:0] M_INDX   = 4'd7;
  localparam logic [MW-1:0] M_INDY   = 4'd8;
  localparam logic [MW-1:0] M_JIND   = 4'd9;
  localparam logic [MW-1:0] M_BRANCH = 4'd10;

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_STORE = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} fetch_st_e;

  // Zero-page address: the sum keeps only its low byte
  function automatic logic [AW-1:0] zp_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] s;
    s = a + b;
    return {{(AW-DW){1'b0}}, s};
  endfunction

  function automatic logic page_differs(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:DW] != b[AW-1:DW];
  endfunction

  // Next byte within the same page (low byte wraps, high byte kept)
  function automatic logic [AW-1:0] same_page_next(input logic [AW-1:0] p);
    logic [DW-1:0] lo;
    lo = p[DW-1:0] + 1'b1;
    return {p[AW-1:DW], lo};
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] pc, input logic [DW-1:0] off);
    return pc + {{(AW-DW){off[DW-1]}}, off};
  endfunction

  function automatic logic uses_ptr(input logic [MW-1:0] m);
    return (m == M_INDX) || (m == M_INDY) || (m == M_JIND);
  endfunction

  function automatic logic may_cross(input logic [MW-1:0] m, input logic [1:0] k);
    return ((m == M_ABSX) || (m == M_ABSY) || (m == M_INDY)) && (k == K_READ);
  endfunction

  function automatic logic [CW-1:0] base_cycles(input logic [MW-1:0] m, input logic [1:0] k);
    logic rmw;
    logic st;
    rmw = k[1];
    st  = (k == K_STORE);
    case (m)
      M_ZP:                 return rmw ? 4'd5 : 4'd3;
      M_ZPX, M_ZPY, M_ABS:  return rmw ? 4'd6 : 4'd4;
      M_ABSX, M_ABSY:       return rmw ? 4'd7 : (st ? 4'd5 : 4'd4);
      M_INDX:               return rmw ? 4'd8 : 4'd6;
      M_INDY:               return rmw ? 4'd8 : (st ? 4'd6 : 4'd5);
      M_JIND:               return 4'd5;
      default:              return 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/eacyc_addr.sv
module eacyc_addr
  import eacyc_pkg::*;
(
  input  logic [MW-1:0] mode_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] base_o,
  output logic          cross_o
);
  logic [AW-1:0] abs_w;
  logic [AW-1:0] zp_w;

  assign abs_w = {hi_i, lo_i};
  assign zp_w  = zp_add(lo_i, '0);

  always_comb begin
    base_o = pc_i - 1'b1;
    ea_o   = pc_i - 1'b1;
    case (mode_i)
      M_ZP:     begin base_o = zp_w;  ea_o = zp_w;                end
      M_ZPX:    begin base_o = zp_w;  ea_o = zp_add(lo_i, x_i);   end
      M_ZPY:    begin base_o = zp_w;  ea_o = zp_add(lo_i, y_i);   end
      M_ABS:    begin base_o = abs_w; ea_o = abs_w;               end
      M_ABSX:   begin base_o = abs_w; ea_o = abs_w + {{(AW-DW){1'b0}}, x_i}; end
      M_ABSY:   begin base_o = abs_w; ea_o = abs_w + {{(AW-DW){1'b0}}, y_i}; end
      M_INDX:   begin base_o = ptr_i; ea_o = ptr_i;               end
      M_INDY:   begin base_o = ptr_i; ea_o = ptr_i + {{(AW-DW){1'b0}}, y_i}; end
      M_JIND:   begin base_o = abs_w; ea_o = ptr_i;               end
      M_BRANCH: begin base_o = pc_i;  ea_o = rel_target(pc_i, lo_i); end
      default:  ;
    endcase
  end

  assign cross_o = page_differs(base_o, ea_o);
endmodule

// File: rtl/eacyc_cycles.sv
module eacyc_cycles
  import eacyc_pkg::*;
(
  input  logic [MW-1:0] mode_i,
  input  logic [1:0]    kind_i,
  input  logic          cross_i,
  input  logic          taken_i,
  output logic          pen_taken_o,
  output logic          pen_page_o,
  output logic [CW-1:0] cycles_o
);
  logic is_branch;

  assign is_branch   = (mode_i == M_BRANCH);
  assign pen_taken_o = is_branch && taken_i;
  assign pen_page_o  = cross_i && (pen_taken_o || may_cross(mode_i, kind_i));
  assign cycles_o    = base_cycles(mode_i, kind_i) + CW'(pen_taken_o) + CW'(pen_page_o);
endmodule

// File: rtl/eacyc_fetch.sv
module eacyc_fetch
  import eacyc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          need_ptr_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] ptr_o,
  output logic          finish_o,
  output logic          busy_o
);
  fetch_st_e state;
  logic [DW-1:0] byte_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (go_i) state <= need_ptr_i ? S_LO : S_FIN;
        S_LO:    if (mem_ack_i) state <= S_HI;
        S_HI:    if (mem_ack_i) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_byte
      logic grab;
      assign grab = mem_ack_i && (state == ((b == 0) ? S_LO : S_HI));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    byte_q[b] <= '0;
        else if (grab) byte_q[b] <= mem_rdata_i;
      end
    end
  endgenerate

  assign mem_req_o  = (state == S_LO) || (state == S_HI);
  assign mem_addr_o = (state == S_HI) ? same_page_next(first_addr_i) : first_addr_i;
  assign ptr_o      = {byte_q[1], byte_q[0]};
  assign finish_o   = (state == S_FIN);
  assign busy_o     = (state != S_IDLE);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);
endmodule

// File: rtl/eacyc_unit.sv
module eacyc_unit
  import eacyc_pkg::*;
#(
  parameter int CYC_W = CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       mode_i,
  input  logic [1:0]       kind_i,
  input  logic [7:0]       op_lo_i,
  input  logic [7:0]       op_hi_i,
  input  logic [7:0]       x_i,
  input  logic [7:0]       y_i,
  input  logic [15:0]      next_pc_i,
  input  logic             taken_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [15:0]      mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             done_o,
  output logic [15:0]      ea_o,
  output logic [15:0]      base_o,
  output logic [CYC_W-1:0] cycles_o
);
  logic [MW-1:0] mode_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] lo_q, hi_q, x_q, y_q;
  logic [AW-1:0] pc_q;
  logic          taken_q;

  logic          go, finish, cross_w, pen_page, pen_taken;
  logic [AW-1:0] first_addr, ptr_w, ea_w, base_w;
  logic [CW-1:0] cyc_w;

  logic [AW-1:0]    ea_q, base_q;
  logic [CYC_W-1:0] cyc_q;
  logic             done_q;

  assign go = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; kind_q <= '0; lo_q <= '0; hi_q <= '0;
      x_q <= '0; y_q <= '0; pc_q <= '0; taken_q <= 1'b0;
    end else if (go) begin
      mode_q <= mode_i; kind_q <= kind_i; lo_q <= op_lo_i; hi_q <= op_hi_i;
      x_q <= x_i; y_q <= y_i; pc_q <= next_pc_i; taken_q <= taken_i;
    end
  end

  always_comb begin
    case (mode_q)
      M_INDX:  first_addr = zp_add(lo_q, x_q);
      M_INDY:  first_addr = zp_add(lo_q, '0);
      default: first_addr = {hi_q, lo_q};
    endcase
  end

  eacyc_fetch u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .need_ptr_i   (uses_ptr(mode_i)),
    .first_addr_i (first_addr),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .ptr_o        (ptr_w),
    .finish_o     (finish),
    .busy_o       (busy_o)
  );

  eacyc_addr u_addr (
    .mode_i  (mode_q),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .x_i     (x_q),
    .y_i     (y_q),
    .pc_i    (pc_q),
    .ptr_i   (ptr_w),
    .ea_o    (ea_w),
    .base_o  (base_w),
    .cross_o (cross_w)
  );

  eacyc_cycles u_cyc (
    .mode_i      (mode_q),
    .kind_i      (kind_q),
    .cross_i     (cross_w),
    .taken_i     (taken_q),
    .pen_taken_o (pen_taken),
    .pen_page_o  (pen_page),
    .cycles_o    (cyc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0; base_q <= '0; cyc_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        ea_q   <= ea_w;
        base_q <= base_w;
        cyc_q  <= CYC_W'(cyc_w);
      end
    end
  end

  assign done_o   = done_q;
  assign ea_o     = ea_q;
  assign base_o   = base_q;
  assign cycles_o = cyc_q;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_zp_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (mode_q == M_ZPX || mode_q == M_ZPY)) |-> (ea_q[AW-1:DW] == '0));

  assert_cyc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cyc_q >= CYC_W'(2) && cyc_q <= CYC_W'(8)));

  assert_no_pen_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q != K_READ && mode_q != M_BRANCH) |-> (cyc_q == CYC_W'(base_cycles(mode_q, kind_q))));

  assert_branch_untaken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == M_BRANCH && !taken_q) |-> (cyc_q == CYC_W'(2)));

  assert_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !uses_ptr(mode_q)) |-> !mem_req_o);

  assert_ignore_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(lo_q) && $stable(pc_q)));
endmodule

// File: tb/eacyc_unit_tb.sv
module eacyc_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, taken, busy, mem_req, mem_ack, done;
  logic [3:0] mode, cyc;
  logic [1:0] kind;
  logic [7:0] lo, hi, xr, yr, mem_rdata;
  logic [15:0] npc, mem_addr, ea, base;

  int checks = 0;
  int errors = 0;
  logic [7:0] zp [256];
  int lat = 0;
  int lat_cnt = 0;

  eacyc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .kind_i(kind),
    .op_lo_i(lo), .op_hi_i(hi), .x_i(xr), .y_i(yr), .next_pc_i(npc), .taken_i(taken),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .ea_o(ea), .base_o(base), .cycles_o(cyc)
  );

  function automatic logic [7:0] mb(input int a);
    if (a < 256) return zp[a];
    return 8'((a % 256) * 37) ^ 8'(a / 256) ^ 8'h5C;
  endfunction

  // memory slave with programmable acknowledge latency
  always @(negedge clk) begin
    if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ack <= 1'b1; mem_rdata <= mb(int'(mem_addr)); lat_cnt <= 0;
      end else begin
        mem_ack <= 1'b0; lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0; lat_cnt <= 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ref_model(input int m, input int k, input int l, input int h, input int x,
                           input int y, input int pc, input int tk,
                           output int a0, output int a1, output int n,
                           output int e_ea, output int e_base, output int e_cyc);
    int ab, ptr, rmw, st, off;
    ab = h * 256 + l; rmw = (k >= 2); st = (k == 1);
    n = 0; a0 = 0; a1 = 0;
    case (m)
      1: begin e_base = l; e_ea = l; e_cyc = rmw ? 5 : 3; end
      2, 3: begin e_base = l; e_ea = (l + ((m == 2) ? x : y)) % 256; e_cyc = rmw ? 6 : 4; end
      4: begin e_base = ab; e_ea = ab; e_cyc = rmw ? 6 : 4; end
      5, 6: begin
        e_base = ab; e_ea = (ab + ((m == 5) ? x : y)) % 65536;
        e_cyc = rmw ? 7 : (st ? 5 : 4 + int'((e_ea / 256) != (ab / 256)));
      end
      7: begin
        a0 = (l + x) % 256; a1 = (a0 + 1) % 256; n = 2;
        ptr = mb(a0) + 256 * mb(a1); e_base = ptr; e_ea = ptr; e_cyc = rmw ? 8 : 6;
      end
      8: begin
        a0 = l; a1 = (l + 1) % 256; n = 2;
        ptr = mb(a0) + 256 * mb(a1); e_base = ptr; e_ea = (ptr + y) % 65536;
        e_cyc = rmw ? 8 : (st ? 6 : 5 + int'((e_ea / 256) != (ptr / 256)));
      end
      9: begin
        a0 = ab; a1 = h * 256 + (l + 1) % 256; n = 2;
        e_ea = mb(a0) + 256 * mb(a1); e_base = ab; e_cyc = 5;
      end
      10: begin
        off = (l >= 128) ? l - 256 : l;
        e_base = pc; e_ea = (pc + off + 65536) % 65536;
        e_cyc = 2 + (tk != 0 ? 1 + int'((e_ea / 256) != (pc / 256)) : 0);
      end
      default: begin e_base = (pc + 65535) % 65536; e_ea = e_base; e_cyc = 2; end
    endcase
  endtask

  task automatic run(input string req, input int m, input int k, input int l, input int h,
                     input int x, input int y, input int pc, input int tk, input int latency,
                     input bit inject);
    int a0, a1, n, e_ea, e_base, e_cyc;
    int idx, trig, s;
    bit got;
    ref_model(m, k, l, h, x, y, pc, tk, a0, a1, n, e_ea, e_base, e_cyc);
    lat = latency; idx = 0; trig = 0; s = 0; got = 0;
    @(negedge clk);
    mode = 4'(m); kind = 2'(k); lo = 8'(l); hi = 8'(h); xr = 8'(x); yr = 8'(y);
    npc = 16'(pc); taken = tk[0]; start = 1'b1;
    while (s < 100 && !got) begin
      @(negedge clk); #2; s++;
      if (s == 1) start = 1'b0;
      if (inject && s == 2) begin
        start = 1'b1; mode = 4'd0; lo = 8'hAA; npc = 16'h4444;
      end
      if (inject && s == 3) start = 1'b0;
      if (mem_req) begin
        if (idx >= n) chk(req, "unexpected mem_req", 1, 0);
        else chk(req, "mem_addr", mem_addr, (idx == 0) ? a0 : a1);
        if (mem_ack) begin idx++; trig = s; end
      end
      if (done) begin
        got = 1;
        chk(req, "done timing", s, trig + 2);
        chk(req, "ea", ea, e_ea);
        chk(req, "base", base, e_base);
        chk(req, "cycles", cyc, e_cyc);
        chk(req, "fetch count", idx, n);
      end
    end
    if (!got) chk(req, "done seen", 0, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk(req, "done single pulse / no extra", done, 0);
      chk(req, "result held R11", {ea, base}, {16'(e_ea), 16'(e_base)});
    end
    if (inject) chk(req, "busy after ignored start", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) zp[i] = 8'(i * 13 + 7);
    zp[8'hFF] = 8'h34; zp[8'h00] = 8'h12; zp[8'h40] = 8'hF0; zp[8'h41] = 8'h20;
    rst_n = 1'b0; start = 1'b0; mode = '0; kind = '0; lo = '0; hi = '0;
    xr = '0; yr = '0; npc = '0; taken = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R13", "reset done", done, 0);
    chk("R13", "reset busy", busy, 0);
    chk("R13", "reset mem_req", mem_req, 0);
    chk("R13", "reset results", {ea, base, cyc}, 0);
    rst_n = 1'b1;

    run("R10 immediate", 0, 0, 8'h55, 0, 0, 0, 16'h1235, 0, 0, 0);
    run("R10 reserved mode", 12, 2, 8'h55, 8'h66, 0, 0, 16'h8000, 1, 0, 0);
    run("R2 zp read", 1, 0, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    run("R7 zp rmw", 1, 2, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    run("R2 zp,X wrap", 2, 0, 8'hF0, 0, 8'h20, 0, 0, 0, 0, 0);
    run("R2 zp,Y rmw", 3, 3, 8'h10, 0, 0, 8'hF5, 0, 0, 0, 0);
    run("R3 abs store", 4, 1, 8'h34, 8'h12, 0, 0, 0, 0, 0, 0);
    run("R8 abs,X read cross", 5, 0, 8'hF0, 8'h12, 8'h20, 0, 0, 0, 0, 0);
    run("R8 abs,X store cross", 5, 1, 8'hF0, 8'h12, 8'h20, 0, 0, 0, 0, 0);
    run("R7 abs,X rmw cross", 5, 2, 8'hF0, 8'h12, 8'h20, 0, 0, 0, 0, 0);
    run("R3 abs,Y read same page", 6, 0, 8'h10, 8'h12, 0, 8'h05, 0, 0, 0, 0);
    run("R3 abs,Y top wrap", 6, 0, 8'hFF, 8'hFF, 0, 8'h02, 0, 0, 0, 0);
    run("R4 (zp,X) wrap", 7, 0, 8'hFE, 0, 8'h01, 0, 0, 0, 0, 0);
    run("R4 (zp,X) store slow", 7, 1, 8'h30, 0, 8'h10, 0, 0, 0, 2, 0);
    run("R7 (zp,X) rmw", 7, 2, 8'h3F, 0, 8'h01, 0, 0, 0, 1, 0);
    run("R8 (zp),Y read cross", 8, 0, 8'h40, 0, 0, 8'h10, 0, 0, 1, 0);
    run("R5 (zp),Y read same page", 8, 0, 8'h40, 0, 0, 8'h05, 0, 0, 0, 0);
    run("R8 (zp),Y store cross", 8, 1, 8'h40, 0, 0, 8'h10, 0, 0, 0, 0);
    run("R5 (zp),Y pointer wrap", 8, 2, 8'hFF, 0, 0, 8'h01, 0, 0, 3, 0);
    run("R6 indirect jump page end", 9, 0, 8'hFF, 8'h30, 0, 0, 0, 0, 1, 0);
    run("R6 indirect jump mid page", 9, 0, 8'h10, 8'h31, 0, 0, 0, 0, 0, 0);
    run("R9 branch not taken", 10, 0, 8'h20, 0, 0, 0, 16'h10F0, 0, 0, 0);
    run("R9 branch taken same page", 10, 0, 8'h05, 0, 0, 0, 16'h1010, 1, 0, 0);
    run("R9 branch taken fwd cross", 10, 0, 8'h20, 0, 0, 0, 16'h10F0, 1, 0, 0);
    run("R9 branch taken back cross", 10, 2, 8'hF0, 0, 0, 0, 16'h1005, 1, 0, 0);
    run("R1 start while busy ignored", 9, 0, 8'hFF, 8'h30, 0, 0, 0, 0, 4, 1);
    run("R12 held request long stall", 7, 0, 8'hFE, 0, 8'h01, 0, 0, 0, 5, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule